// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader with Address-Width Discovery

This block reads 16-bit words from a serial EEPROM that uses chip select, a shift clock, a data line into the device and a data line out of it. Each word is fetched with a bit-serial read: a three-bit command, the word address, and sixteen data bits. The shift clock runs at a rate set by a parameter. Each clock phase lasts a fixed number of system clock cycles.

The address width of the attached device is not fixed at build time. The first request after reset runs a sizing read at address zero. The device pulls its data output low once it has received its full address, and the block stops shifting address bits at that point. The number of address bits sent is the device's address width, and the device holds 2^width words. If the device never pulls the line low, the width saturates at the maximum and an error flag is raised.

A dump request walks every word from address 0 upward and adds the words into a 16-bit sum. The contents count as valid when that sum equals 0xBABA. A single-word request returns one word at the requested address, taken modulo the device size.

Top module: `uwire_rom_reader`

## Requirements
- R1: After reset, ee_cs_o, ee_sk_o, ee_di_o, done_o, width_vld_o, size_err_o, sum_valid_o and sum_ok_o are all 0.
- R2: Every device transaction raises ee_cs_o first. It then shifts the command bits 1, 1, 0 (in that order), followed by the address MSB first. A normal read totals 3 + width + 16 clock rises.
- R3: ee_di_o changes only while ee_sk_o is low. Every high phase of ee_sk_o lasts exactly PHASE_CYC cycles. Every low phase inside a transaction lasts at least PHASE_CYC cycles. ee_sk_o rises only while ee_cs_o is high.
- R4: The first request after reset is preceded by a sizing read of address 0. This read sends up to ADDR_W zero address bits and stops after the first bit at which ee_do_i is sampled 0. width_o then equals the number of address bits sent, width_vld_o goes to 1, and the sizing read produces no done_o.
- R5: If ee_do_i is still 1 after ADDR_W address bits, width_o becomes ADDR_W and size_err_o becomes 1.
- R6: After the address, 16 data bits are sampled MSB first while ee_sk_o is high. The word appears on data_o together with a done_o pulse that lasts one cycle.
- R7: After each word, ee_cs_o, ee_sk_o and ee_di_o are all low, and ee_cs_o stays low for at least PHASE_CYC cycles before the next transaction.
- R8: A start_i pulse reads the word at the low width_o bits of addr_i and produces exactly one done_o.
- R9: A dump_i pulse clears sum_valid_o and then reads addresses 0 to 2^width-1 in ascending order, one done_o per word. After the last word, sum_valid_o is set and sum_ok_o equals (word sum mod 2^16 == 0xBABA).
- R10: start_i and dump_i are ignored while a request is in progress. No extra word or done_o results from them.
- R11: Once the width is known, it is kept until reset. Later requests perform exactly one device transaction per word, with no further sizing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-word read request |
| dump_i | input | 1 | Full-contents read and checksum request |
| addr_i | input | ADDR_W | Word address for start_i |
| data_o | output | WORD_W | Last word read |
| done_o | output | 1 | One-cycle strobe, data_o valid |
| ee_cs_o | output | 1 | Device chip select |
| ee_sk_o | output | 1 | Device shift clock |
| ee_di_o | output | 1 | Serial data to device |
| ee_do_i | input | 1 | Serial data from device |
| width_o | output | $clog2(ADDR_W+1) | Detected address width |
| width_vld_o | output | 1 | width_o holds a detected value |
| size_err_o | output | 1 | No dummy zero seen while sizing |
| sum_valid_o | output | 1 | Dump finished, sum_ok_o meaningful |
| sum_ok_o | output | 1 | Word sum matched 0xBABA |

## Verification
The bench builds the block with PHASE_CYC=2, ADDR_W=8 and WORD_W=16. It attaches a device model whose address width is swept over every value from 1 to 8, plus a model that never drives its dummy zero. These settings reach every possible detected width, the saturation path, and full dumps from 2 up to 256 words. The two-cycle phase keeps the 256-word dumps short, yet it still separates sampling on the last high cycle from the clock edges.

// File: rtl/uw_rd_pkg.sv
package uw_rd_pkg;
  typedef enum logic [1:0] {B_IDLE, B_LO, B_HI} bit_st_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SELECT, SQ_OPCODE, SQ_ADDR, SQ_DATA, SQ_DESEL, SQ_DONE
  } sq_st_e;
  typedef enum logic [1:0] {CT_IDLE, CT_SIZE, CT_SINGLE, CT_DUMP} ct_st_e;
  localparam int CMD_BITS = 3;
  localparam logic [CMD_BITS-1:0] RD_CMD = 3'b110;  // start 1, then read 10
endpackage

// File: rtl/uw_rd_bit.sv
module uw_rd_bit
  import uw_rd_pkg::*;
#(
  parameter int PHASE_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bit_i,
  input  logic clr_i,
  input  logic so_i,
  output logic sk_o,
  output logic si_o,
  output logic ack_o,
  output logic smp_o
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  bit_st_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      sk_o  <= 1'b0;
      si_o  <= 1'b0;
      ack_o <= 1'b0;
      smp_o <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      unique case (st_q)
        B_IDLE: begin
          if (req_i) begin
            si_o  <= bit_i;
            cnt_q <= '0;
            st_q  <= B_LO;
          end else if (clr_i) begin
            si_o <= 1'b0;
          end
        end
        B_LO: begin
          if (cnt_q == CNT_LAST) begin
            sk_o  <= 1'b1;
            cnt_q <= '0;
            st_q  <= B_HI;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        B_HI: begin
          if (cnt_q == CNT_LAST) begin
            sk_o  <= 1'b0;
            smp_o <= so_i;  // sampled on last high cycle
            ack_o <= 1'b1;
            st_q  <= B_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uw_rd_seq.sv
module uw_rd_seq
  import uw_rd_pkg::*;
#(
  parameter int PHASE_CYC = 50,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 16,
  localparam int WID_W    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic              bit_ack_i,
  input  logic              bit_smp_i,
  output logic              bit_req_o,
  output logic              bit_val_o,
  output logic              bit_clr_o,
  output logic              cs_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_done_o,
  output logic              size_hit_o,
  output logic [WID_W-1:0]  size_w_o,
  output logic              size_err_o
);
  localparam int MAXB = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
  localparam int IW   = $clog2(MAXB + 1);
  localparam int CW   = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  sq_st_e st_q;
  logic [IW-1:0]     idx_q;
  logic [CW-1:0]     wcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sizing_q;
  logic              wait_q;
  logic [WORD_W-1:0] shr_q;
  logic [ADDR_W-1:0] addr_sh;
  logic [CMD_BITS-1:0] cmd_sh;

  assign addr_sh = addr_q >> idx_q;
  assign cmd_sh  = RD_CMD >> idx_q;

  always_comb begin
    bit_req_o = 1'b0;
    bit_val_o = 1'b0;
    unique case (st_q)
      SQ_OPCODE: begin
        bit_req_o = !wait_q;
        bit_val_o = cmd_sh[0];
      end
      SQ_ADDR: begin
        bit_req_o = !wait_q;
        bit_val_o = sizing_q ? 1'b0 : addr_sh[0];
      end
      SQ_DATA: bit_req_o = !wait_q;
      default: ;
    endcase
  end

  assign bit_clr_o   = (st_q == SQ_DESEL);
  assign word_done_o = (st_q == SQ_DONE);
  assign word_o      = shr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else if (bit_ack_i) wait_q <= 1'b0;
    else if (bit_req_o) wait_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      idx_q      <= '0;
      wcnt_q     <= '0;
      addr_q     <= '0;
      sizing_q   <= 1'b0;
      shr_q      <= '0;
      cs_o       <= 1'b0;
      size_hit_o <= 1'b0;
      size_w_o   <= '0;
      size_err_o <= 1'b0;
    end else begin
      size_hit_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (go_i) begin
            cs_o     <= 1'b1;
            addr_q   <= addr_i;
            sizing_q <= size_i;
            wcnt_q   <= '0;
            st_q     <= SQ_SELECT;
          end
        end
        SQ_SELECT: begin
          if (wcnt_q == CNT_LAST) begin
            idx_q <= IW'(CMD_BITS - 1);
            st_q  <= SQ_OPCODE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        SQ_OPCODE: begin
          if (bit_ack_i) begin
            if (idx_q == '0) begin
              idx_q <= sizing_q ? IW'(ADDR_W - 1) : (IW'(width_i) - IW'(1));
              st_q  <= SQ_ADDR;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        SQ_ADDR: begin
          if (bit_ack_i) begin
            if (sizing_q && !bit_smp_i) begin
              size_hit_o <= 1'b1;
              size_w_o   <= WID_W'(ADDR_W - int'(idx_q));
              size_err_o <= 1'b0;
              idx_q      <= IW'(WORD_W - 1);
              st_q       <= SQ_DATA;
            end else if (idx_q == '0) begin
              if (sizing_q) begin
                size_hit_o <= 1'b1;
                size_w_o   <= WID_W'(ADDR_W);
                size_err_o <= 1'b1;
              end
              idx_q <= IW'(WORD_W - 1);
              st_q  <= SQ_DATA;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        SQ_DATA: begin
          if (bit_ack_i) begin
            shr_q <= {shr_q[WORD_W-2:0], bit_smp_i};
            if (idx_q == '0) begin
              cs_o   <= 1'b0;
              wcnt_q <= '0;
              st_q   <= SQ_DESEL;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        SQ_DESEL: begin
          if (wcnt_q == CNT_LAST) st_q <= SQ_DONE;
          else wcnt_q <= wcnt_q + 1'b1;
        end
        SQ_DONE: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uw_rd_ctrl.sv
module uw_rd_ctrl
  import uw_rd_pkg::*;
#(
  parameter int ADDR_W                  = 8,
  parameter int WORD_W                  = 16,
  parameter logic [WORD_W-1:0] SUM_GOOD = 16'hBABA,
  localparam int WID_W                  = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dump_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_done_i,
  input  logic              size_hit_i,
  input  logic [WID_W-1:0]  size_w_i,
  input  logic              size_err_i,
  output logic              go_o,
  output logic [ADDR_W-1:0] go_addr_o,
  output logic              go_size_o,
  output logic [WID_W-1:0]  width_o,
  output logic              width_vld_o,
  output logic              size_err_o,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o,
  output logic              sum_valid_o,
  output logic              sum_ok_o
);
  ct_st_e st_q;
  logic              dump_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] sum_nx;
  logic [ADDR_W-1:0] last_addr;

  assign sum_nx = sum_q + word_i;

  always_comb begin
    last_addr = '0;
    for (int i = 0; i < ADDR_W; i++) last_addr[i] = (i < int'(width_o));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CT_IDLE;
      dump_q      <= 1'b0;
      req_addr_q  <= '0;
      sum_q       <= '0;
      go_o        <= 1'b0;
      go_addr_o   <= '0;
      go_size_o   <= 1'b0;
      width_o     <= '0;
      width_vld_o <= 1'b0;
      size_err_o  <= 1'b0;
      data_o      <= '0;
      done_o      <= 1'b0;
      sum_valid_o <= 1'b0;
      sum_ok_o    <= 1'b0;
    end else begin
      go_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (st_q)
        CT_IDLE: begin
          if (dump_i || start_i) begin
            dump_q     <= dump_i;
            req_addr_q <= addr_i;
            if (dump_i) begin
              sum_q       <= '0;
              sum_valid_o <= 1'b0;
              sum_ok_o    <= 1'b0;
            end
            go_o <= 1'b1;
            if (!width_vld_o) begin
              go_size_o <= 1'b1;
              go_addr_o <= '0;
              st_q      <= CT_SIZE;
            end else begin
              go_size_o <= 1'b0;
              go_addr_o <= dump_i ? '0 : addr_i;
              st_q      <= dump_i ? CT_DUMP : CT_SINGLE;
            end
          end
        end
        CT_SIZE: begin
          if (size_hit_i) begin
            width_o    <= size_w_i;
            size_err_o <= size_err_i;
          end
          if (word_done_i) begin
            width_vld_o <= 1'b1;
            go_o        <= 1'b1;
            go_size_o   <= 1'b0;
            go_addr_o   <= dump_q ? '0 : req_addr_q;
            st_q        <= dump_q ? CT_DUMP : CT_SINGLE;
          end
        end
        CT_SINGLE: begin
          if (word_done_i) begin
            data_o <= word_i;
            done_o <= 1'b1;
            st_q   <= CT_IDLE;
          end
        end
        CT_DUMP: begin
          if (word_done_i) begin
            data_o <= word_i;
            done_o <= 1'b1;
            sum_q  <= sum_nx;
            if (go_addr_o == last_addr) begin
              sum_valid_o <= 1'b1;
              sum_ok_o    <= (sum_nx == SUM_GOOD);
              st_q        <= CT_IDLE;
            end else begin
              go_addr_o <= go_addr_o + 1'b1;
              go_o      <= 1'b1;
            end
          end
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader
  import uw_rd_pkg::*;
#(
  parameter int PHASE_CYC               = 50,
  parameter int ADDR_W                  = 8,
  parameter int WORD_W                  = 16,
  parameter logic [WORD_W-1:0] SUM_GOOD = 16'hBABA,
  localparam int WID_W                  = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dump_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  output logic [WID_W-1:0]  width_o,
  output logic              width_vld_o,
  output logic              size_err_o,
  output logic              sum_valid_o,
  output logic              sum_ok_o
);
  logic              go;
  logic [ADDR_W-1:0] go_addr;
  logic              go_size;
  logic              bit_req, bit_val, bit_clr, bit_ack, bit_smp;
  logic [WORD_W-1:0] word;
  logic              word_done;
  logic              size_hit;
  logic [WID_W-1:0]  size_w;
  logic              size_err;

  uw_rd_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SUM_GOOD(SUM_GOOD)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dump_i, .addr_i,
    .word_i(word), .word_done_i(word_done),
    .size_hit_i(size_hit), .size_w_i(size_w), .size_err_i(size_err),
    .go_o(go), .go_addr_o(go_addr), .go_size_o(go_size),
    .width_o, .width_vld_o, .size_err_o,
    .data_o, .done_o, .sum_valid_o, .sum_ok_o
  );

  uw_rd_seq #(
    .PHASE_CYC(PHASE_CYC), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .addr_i(go_addr), .size_i(go_size), .width_i(width_o),
    .bit_ack_i(bit_ack), .bit_smp_i(bit_smp),
    .bit_req_o(bit_req), .bit_val_o(bit_val), .bit_clr_o(bit_clr),
    .cs_o(ee_cs_o), .word_o(word), .word_done_o(word_done),
    .size_hit_o(size_hit), .size_w_o(size_w), .size_err_o(size_err)
  );

  uw_rd_bit #(
    .PHASE_CYC(PHASE_CYC)
  ) u_bit (
    .clk_i, .rst_ni,
    .req_i(bit_req), .bit_i(bit_val), .clr_i(bit_clr), .so_i(ee_do_i),
    .sk_o(ee_sk_o), .si_o(ee_di_o), .ack_o(bit_ack), .smp_o(bit_smp)
  );
endmodule

// File: rtl/uwire_rom_reader_chk.sv
module uwire_rom_reader_chk #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  localparam int WID_W = $clog2(ADDR_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] data_o,
  input logic              done_o,
  input logic              ee_cs_o,
  input logic              ee_sk_o,
  input logic              ee_di_o,
  input logic [WID_W-1:0]  width_o,
  input logic              width_vld_o,
  input logic              size_err_o,
  input logic              sum_valid_o,
  input logic              sum_ok_o
);
  p_desel_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> (!ee_sk_o && !ee_di_o));

  p_di_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

  p_sk_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_sk_o) |-> ee_cs_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |-> (width_o == WID_W'(ADDR_W)));

  p_width_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_vld_o |-> (width_o >= WID_W'(1) && width_o <= WID_W'(ADDR_W)));

  p_width_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_vld_o && $past(width_vld_o)) |-> $stable(width_o));

  p_sum_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_ok_o |-> sum_valid_o);
endmodule

bind uwire_rom_reader uwire_rom_reader_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_o(data_o), .done_o(done_o),
  .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o),
  .width_o(width_o), .width_vld_o(width_vld_o), .size_err_o(size_err_o),
  .sum_valid_o(sum_valid_o), .sum_ok_o(sum_ok_o)
);

// File: tb/uwire_rom_reader_test.sv
`timescale 1ns/1ps
module uwire_rom_reader_test;
  localparam int PH = 2;
  localparam int AW = 8;
  localparam int WW = 16;
  localparam int WIDW = $clog2(AW + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic dump_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [WW-1:0] data_o;
  logic done_o, ee_cs_o, ee_sk_o, ee_di_o;
  logic ee_do_i = 1'b1;
  logic [WIDW-1:0] width_o;
  logic width_vld_o, size_err_o, sum_valid_o, sum_ok_o;

  always #2 clk = ~clk;

  uwire_rom_reader #(.PHASE_CYC(PH), .ADDR_W(AW), .WORD_W(WW)) uut (
    .clk_i(clk), .rst_ni, .start_i, .dump_i, .addr_i, .data_o, .done_o,
    .ee_cs_o, .ee_sk_o, .ee_di_o, .ee_do_i, .width_o, .width_vld_o,
    .size_err_o, .sum_valid_o, .sum_ok_o
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  int dev_aw = 1;
  bit no_zero = 1'b0;
  logic [WW-1:0] mem [256];
  int rises = 0, last_rises = 0, txn = 0, cmd_bad = 0;
  logic [2:0] cmd = '0;
  logic [7:0] rx_addr = '0, last_addr = '0;
  logic [WW-1:0] word = '0;
  logic m_cs = 1'b0, m_sk = 1'b0;

  always @(negedge clk) begin
    if (ee_cs_o && !m_cs) begin
      rises = 0; cmd = '0; rx_addr = '0; ee_do_i = 1'b1; txn++;
    end else if (!ee_cs_o && m_cs) begin
      last_rises = rises; last_addr = rx_addr; ee_do_i = 1'b1;
      if (cmd != 3'b110) cmd_bad++;
    end
    if (ee_cs_o && ee_sk_o && !m_sk) begin
      rises++;
      if (rises <= 3) cmd = {cmd[1:0], ee_di_o};
      else if (rises <= 3 + dev_aw) begin
        rx_addr = {rx_addr[6:0], ee_di_o};
        if (rises == 3 + dev_aw && !no_zero) begin
          ee_do_i = 1'b0;
          word = mem[rx_addr];
        end
      end else if (rises <= 3 + dev_aw + 16 && !no_zero) begin
        ee_do_i = word[15];
        word = word << 1;
      end
    end
    m_cs = ee_cs_o;
    m_sk = ee_sk_o;
  end

  // serial timing monitor
  int hi_run = 0, lo_run = 0, cs_lo = 0;
  int v_hi = 0, v_lo = 0, v_di = 0, v_cs = 0, v_q = 0;
  logic p_sk = 1'b0, p_di = 1'b0, p_cs = 1'b0;
  bit seen_cs = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ee_sk_o) begin
        if (!p_sk && ee_cs_o && lo_run < PH) v_lo++;
        hi_run++;
        lo_run = 0;
      end else begin
        if (p_sk && hi_run != PH) v_hi++;
        hi_run = 0;
        if (ee_cs_o) lo_run++;
      end
      if (ee_sk_o && p_sk && ee_di_o !== p_di) v_di++;
      if (!ee_cs_o) begin
        cs_lo++;
        lo_run = 0;
        if (ee_sk_o || ee_di_o) v_q++;
      end else if (!p_cs) begin
        if (seen_cs && cs_lo < PH) v_cs++;
        seen_cs = 1'b1;
        cs_lo = 0;
      end
    end
    p_sk = ee_sk_o; p_di = ee_di_o; p_cs = ee_cs_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {ee_cs_o, ee_sk_o, ee_di_o, done_o, width_vld_o,
        size_err_o, sum_valid_o, sum_ok_o} == 8'h00,
        {ee_cs_o, ee_sk_o, ee_di_o, done_o, width_vld_o, size_err_o, sum_valid_o, sum_ok_o}, 0);
  endtask

  task automatic fill(input int aw, input bit good);
    logic [WW-1:0] s = '0;
    int n = 1 << aw;
    for (int a = 0; a < n - 1; a++) begin
      mem[a] = WW'(a * 16'h1357 + aw * 16'h0F0F + 16'h2468);
      s = s + mem[a];
    end
    mem[n-1] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
  endtask

  task automatic rd_one(input logic [7:0] a, input logic [WW-1:0] exp, output int ntx);
    int t0 = txn;
    int extra = 0;
    @(negedge clk) addr_i = a; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R8 R6 single word data", data_o == exp, data_o, exp);
    ntx = txn - t0;
    repeat (20) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk("R8 one done per read", extra == 0, extra, 0);
  endtask

  task automatic dump_all(input int n, input bit sat);
    int k = 0, bad = 0, post = 0;
    bit poked = 1'b0;
    logic [WW-1:0] s = '0;
    @(negedge clk) dump_i = 1'b1;
    @(negedge clk) dump_i = 1'b0;
    chk("R9 sum_valid cleared at dump start", sum_valid_o == 1'b0, sum_valid_o, 0);
    while (!sum_valid_o) begin
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) begin
        logic [WW-1:0] e;
        e = sat ? 16'hFFFF : mem[k];
        if (data_o !== e) bad++;
        s = s + e;
        k++;
        if (k == 1 && !poked) begin
          start_i = 1'b1; dump_i = 1'b0; poked = 1'b1;
        end
      end
    end
    start_i = 1'b0;
    chk("R9 dump word count", k == n, k, n);
    chk("R9 R6 dump words in address order", bad == 0, bad, 0);
    chk("R9 checksum verdict", sum_ok_o == (s == 16'hBABA), sum_ok_o, (s == 16'hBABA));
    repeat (60) begin
      @(negedge clk);
      if (done_o) post++;
    end
    chk("R10 request during dump ignored", post == 0, post, 0);
  endtask

  initial begin
    int ntx;
    for (int aw = 1; aw <= 8; aw++) begin
      logic [7:0] msk;
      logic [7:0] a1, a2;
      dev_aw = aw;
      no_zero = 1'b0;
      fill(aw, aw != 5);
      do_reset();
      msk = 8'((1 << aw) - 1);
      a1 = 8'hA5 ^ 8'(aw * 37);
      a2 = ~a1;
      rd_one(a1, mem[a1 & msk], ntx);
      chk("R4 sizing read precedes first word", ntx == 2, ntx, 2);
      chk("R4 detected width", width_o == WIDW'(aw), width_o, aw);
      chk("R4 width valid", width_vld_o == 1'b1, width_vld_o, 1);
      chk("R5 no error when zero seen", size_err_o == 1'b0, size_err_o, 0);
      chk("R2 rises per read", last_rises == 3 + aw + 16, last_rises, 3 + aw + 16);
      chk("R8 R2 address sent MSB first", last_addr == (a1 & msk), last_addr, a1 & msk);
      rd_one(a2, mem[a2 & msk], ntx);
      chk("R11 no resizing on later read", ntx == 1, ntx, 1);
      chk("R11 width kept", width_o == WIDW'(aw), width_o, aw);
      dump_all(1 << aw, 1'b0);
    end
    chk("R2 command bits 1,1,0", cmd_bad == 0, cmd_bad, 0);

    dev_aw = 8;
    no_zero = 1'b1;
    do_reset();
    dump_all(256, 1'b1);
    chk("R5 width saturates", width_o == WIDW'(AW), width_o, AW);
    chk("R5 error flag set", size_err_o == 1'b1, size_err_o, 1);
    chk("R5 full address sent", last_rises == 3 + 8 + 16, last_rises, 27);

    chk("R3 high phase length", v_hi == 0, v_hi, 0);
    chk("R3 low phase length", v_lo == 0, v_lo, 0);
    chk("R3 di stable while sk high", v_di == 0, v_di, 0);
    chk("R7 deselect gap", v_cs == 0, v_cs, 0);
    chk("R7 outputs low when deselected", v_q == 0, v_q, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule